// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

This block holds two byte-wide event counters. Each counter takes its own event input, which arrives already synchronized to the clock and reduced to a one-cycle pulse per edge. By default the two counters run separately and each one wraps without any notice. When the cascade control bit is set, the two counters form one 16-bit counter. The lower counter is the low byte and counts the low event input. The upper counter is the high byte and advances on each carry out of the low byte. A wrap of the high byte sets an overflow flag, and that flag can drive an interrupt line.

Software reaches the block through a simple register port with a 2-bit register select. A word-wide access to the low-count register reads or loads both bytes in the same cycle. Byte reads are not latched. Two byte reads made at different times can therefore show a torn value, while a single word read always shows a consistent one. A write to a count register takes priority over a count pulse that lands in the same cycle.

Top module: `pacc_dual`

## Requirements
- R1: After reset the control bits, the overflow flag, both counts and the interrupt output are all zero.
- R2: When the cascade bit (select 0, bit 0) is clear, the low count advances on each low event, the high count advances on each high event, and each count wraps from 0xFF to 0x00 without setting the flag (select 1, bit 0).
- R3: When the cascade bit is set, the low count advances on each low event, the high count advances only when the low count carries from 0xFF to 0x00, and the high event input has no effect.
- R4: When the cascade bit is set, a step of the 16-bit count from 0xFFFF to 0x0000 sets the overflow flag in that same clock edge.
- R5: A write to a count byte in the same cycle as an increment of that byte loads the written value, and the increment is lost. A carry out of the low byte into a high byte that is being written is also lost.
- R6: A word access (word strobe set with select 2) reads {high, low} and loads both bytes in one cycle. A byte access with select 2 or 3 reads or writes only the low or the high count, zero-extended, and shows the live value with no latching.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: The interrupt output is high exactly while the overflow flag and the interrupt-enable bit (select 0, bit 1) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_lo | input | 1 | Event pulse for the low counter |
| evt_hi | input | 1 | Event pulse for the high counter (used only when not cascaded) |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 flag, 2 low count, 3 high count |
| bus_word | input | 1 | Word access when paired with select 2 |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default byte width of 8 and two reset synchronizer stages, so the full 16-bit wrap sits only a few events from a preloaded value. Word loads close to 0xFFFF and 0x00FF, together with a count pulse that lands on the same edge as a write, reach the carry, the overflow and the collision cases directly. The tests then read the results back through the same register port that software would use.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_CNTL = 2'd2,
    SEL_CNTH = 2'd3
  } pacc_sel_e;

  localparam int unsigned CTRL_CASC_BIT = 0;
  localparam int unsigned CTRL_IEN_BIT  = 1;
  localparam int unsigned FLAG_OVF_BIT  = 0;
  localparam int unsigned CTRL_BITS     = 2;
endpackage

// File: rtl/pacc_rst_sync.sv
module pacc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pacc_byte_ctr.sv
module pacc_byte_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt;
    cnt_en = ld | inc;
    if (ld)       cnt_d = ld_val;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign wrap = inc & ~ld & (&cnt);

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> cnt == W'($past(cnt) + 1'b1));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt));
endmodule

// File: rtl/pacc_ctl_regs.sv
module pacc_ctl_regs
  import pacc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic [CTRL_BITS-1:0] ctrl_wd,
  input  logic                 flag_we,
  input  logic                 flag_wd,
  input  logic                 ovf_set,
  output logic                 casc_en,
  output logic                 irq_en,
  output logic                 ovf_flag
);
  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 flag_d;
  logic                 flag_clr;

  always_comb begin
    flag_clr = flag_we & flag_wd;
    flag_d   = ovf_flag;
    if (ovf_set)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= flag_d;
  end

  assign casc_en = ctrl_q[CTRL_CASC_BIT];
  assign irq_en  = ctrl_q[CTRL_IEN_BIT];

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_wd && !ovf_set) |=> !ovf_flag);
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_set && !(flag_we && flag_wd)) |=> $stable(ovf_flag));
endmodule

// File: rtl/pacc_dual.sv
module pacc_dual
  import pacc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_lo,
  input  logic                 evt_hi,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_sel,
  input  logic                 bus_word,
  input  logic [2*CNT_W-1:0]   bus_wdata,
  output logic [2*CNT_W-1:0]   bus_rdata,
  output logic                 irq
);
  localparam int unsigned WORD_W = 2 * CNT_W;

  logic             rst_int_n;
  logic             word_hit;
  logic             ld_lo, ld_hi;
  logic [CNT_W-1:0] ld_lo_val, ld_hi_val;
  logic [CNT_W-1:0] cnt_lo, cnt_hi;
  logic             wrap_lo, wrap_hi;
  logic             inc_hi;
  logic             casc_en, irq_en, ovf_flag, ovf_set;
  logic             ctrl_we, flag_we;

  pacc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    word_hit  = bus_word & (bus_sel == SEL_CNTL);
    ld_lo     = bus_wr & (bus_sel == SEL_CNTL);
    ld_hi     = bus_wr & ((bus_sel == SEL_CNTH) | word_hit);
    ld_lo_val = bus_wdata[CNT_W-1:0];
    ld_hi_val = word_hit ? bus_wdata[WORD_W-1:CNT_W] : bus_wdata[CNT_W-1:0];
    ctrl_we   = bus_wr & (bus_sel == SEL_CTRL);
    flag_we   = bus_wr & (bus_sel == SEL_FLAG);
    inc_hi    = casc_en ? wrap_lo : evt_hi;
    ovf_set   = casc_en & wrap_hi;
  end

  pacc_byte_ctr #(.W(CNT_W)) u_lo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .inc    (evt_lo),
    .ld     (ld_lo),
    .ld_val (ld_lo_val),
    .cnt    (cnt_lo),
    .wrap   (wrap_lo)
  );

  pacc_byte_ctr #(.W(CNT_W)) u_hi (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .inc    (inc_hi),
    .ld     (ld_hi),
    .ld_val (ld_hi_val),
    .cnt    (cnt_hi),
    .wrap   (wrap_hi)
  );

  pacc_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctrl_we  (ctrl_we),
    .ctrl_wd  (bus_wdata[CTRL_BITS-1:0]),
    .flag_we  (flag_we),
    .flag_wd  (bus_wdata[FLAG_OVF_BIT]),
    .ovf_set  (ovf_set),
    .casc_en  (casc_en),
    .irq_en   (irq_en),
    .ovf_flag (ovf_flag)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      SEL_CTRL: begin
        bus_rdata[CTRL_CASC_BIT] = casc_en;
        bus_rdata[CTRL_IEN_BIT]  = irq_en;
      end
      SEL_FLAG: bus_rdata[FLAG_OVF_BIT] = ovf_flag;
      SEL_CNTL: begin
        bus_rdata[CNT_W-1:0] = cnt_lo;
        if (bus_word) bus_rdata[WORD_W-1:CNT_W] = cnt_hi;
      end
      SEL_CNTH: bus_rdata[CNT_W-1:0] = cnt_hi;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = ovf_flag & irq_en;

  p_cascade_carry_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (casc_en && evt_lo && (&cnt_lo) && !bus_wr) |=> cnt_hi == CNT_W'($past(cnt_hi) + 1'b1));
  p_cascade_hi_ignored_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (casc_en && !(evt_lo && (&cnt_lo)) && !ld_hi) |=> $stable(cnt_hi));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!casc_en && !flag_we) |=> $stable(ovf_flag) || !ovf_flag);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovf_set && irq_en && !ctrl_we) |=> irq);
  p_word_read_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel == SEL_CNTL && bus_word) |-> bus_rdata == {cnt_hi, cnt_lo});
endmodule

// File: tb/tb_pacc_dual.sv
`timescale 1ns/1ps
module tb_pacc_dual;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_lo = 1'b0, evt_hi = 1'b0;
  logic        bus_wr = 1'b0, bus_word = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pacc_dual dut (
    .clk(clk), .rst_n(rst_n), .evt_lo(evt_lo), .evt_hi(evt_hi),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic w, input logic [15:0] d,
                    input logic ev = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = a; bus_word = w; bus_wdata = d; evt_lo = ev;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0; evt_lo = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic w, output logic [15:0] d);
    bus_sel = a; bus_word = w;
    #0.5;
    d = bus_rdata;
    bus_word = 1'b0;
  endtask

  task automatic pulse(input logic lo, input logic hi, input int n);
    @(negedge clk);
    evt_lo = lo; evt_hi = hi;
    repeat (n) @(negedge clk);
    evt_lo = 1'b0; evt_hi = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], 1'b0, d);
      check("R1 reset register", d, 16'h0000);
    end
    rd(2'd2, 1'b1, d); check("R1 reset word", d, 16'h0000);
    check("R1 reset irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_indep;
    logic [15:0] d;
    wr(2'd2, 1'b0, 16'h00FE);
    wr(2'd3, 1'b0, 16'h0010);
    pulse(1'b1, 1'b1, 3);
    rd(2'd2, 1'b0, d); check("R2 low wraps", d, 16'h0001);
    rd(2'd3, 1'b0, d); check("R2 high counts own event", d, 16'h0013);
    rd(2'd1, 1'b0, d); check("R2 no flag on wrap", d, 16'h0000);
  endtask

  task automatic t_cascade;
    logic [15:0] d;
    wr(2'd0, 1'b0, 16'h0001);
    wr(2'd2, 1'b1, 16'h00FE);
    pulse(1'b1, 1'b1, 3);
    rd(2'd2, 1'b1, d); check("R3 carry into high, high event ignored", d, 16'h0101);
    pulse(1'b0, 1'b1, 4);
    rd(2'd2, 1'b1, d); check("R3 high event alone ignored", d, 16'h0101);
  endtask

  task automatic t_overflow;
    logic [15:0] d;
    wr(2'd0, 1'b0, 16'h0003);
    wr(2'd2, 1'b1, 16'hFFFE);
    pulse(1'b1, 1'b0, 1);
    rd(2'd1, 1'b0, d); check("R4 no flag before wrap", d, 16'h0000);
    pulse(1'b1, 1'b0, 1);
    rd(2'd2, 1'b1, d); check("R4 count wrapped", d, 16'h0000);
    rd(2'd1, 1'b0, d); check("R4 flag set", d, 16'h0001);
    check("R8 irq with enable", {15'd0, irq}, 16'h0001);
    wr(2'd0, 1'b0, 16'h0001);
    check("R8 irq masked", {15'd0, irq}, 16'h0000);
    wr(2'd0, 1'b0, 16'h0003);
    wr(2'd1, 1'b0, 16'h0000);
    rd(2'd1, 1'b0, d); check("R7 write zero keeps flag", d, 16'h0001);
    wr(2'd1, 1'b0, 16'h0001);
    rd(2'd1, 1'b0, d); check("R7 write one clears", d, 16'h0000);
    check("R8 irq drops", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    wr(2'd2, 1'b1, 16'h0110);
    wr(2'd2, 1'b0, 16'h0055, 1'b1);
    rd(2'd2, 1'b1, d); check("R5 byte write beats pulse", d, 16'h0155);
    wr(2'd2, 1'b1, 16'hFFFF, 1'b1);
    rd(2'd2, 1'b1, d); check("R5 word write beats pulse", d, 16'hFFFF);
    rd(2'd1, 1'b0, d); check("R5 no flag on collision", d, 16'h0000);
    wr(2'd2, 1'b1, 16'h00FF);
    wr(2'd3, 1'b0, 16'h0020, 1'b1);
    rd(2'd2, 1'b1, d); check("R5 carry lost to high write", d, 16'h2000);
    wr(2'd2, 1'b1, 16'hFFFF);
    wr(2'd1, 1'b0, 16'h0001, 1'b1);
    rd(2'd1, 1'b0, d); check("R7 set beats clear", d, 16'h0001);
    wr(2'd1, 1'b0, 16'h0001);
  endtask

  task automatic t_access;
    logic [15:0] d;
    wr(2'd2, 1'b1, 16'h1234);
    rd(2'd2, 1'b1, d); check("R6 word read", d, 16'h1234);
    rd(2'd2, 1'b0, d); check("R6 low byte read", d, 16'h0034);
    rd(2'd3, 1'b0, d); check("R6 high byte read", d, 16'h0012);
    pulse(1'b1, 1'b0, 1);
    rd(2'd2, 1'b0, d); check("R6 live byte read", d, 16'h0035);
    wr(2'd3, 1'b0, 16'hAB77);
    rd(2'd2, 1'b1, d); check("R6 byte write high only", d, 16'h7735);
    wr(2'd0, 1'b0, 16'h0000);
    pulse(1'b1, 1'b1, 1);
    rd(2'd2, 1'b1, d); check("R2 after leaving cascade", d, 16'h7836);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_indep();
    t_cascade();
    t_overflow();
    t_collide();
    t_access();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule